// File: doc/BRIEF.md
# Power-On Configuration Sequencer

This controller walks a programmable device from the moment its supplies come up to the point where the user design runs. It waits in a reset phase until three supply-good flags are all high. It then enters an initialization phase, which releases the open-drain init line and captures the 3-bit boot-mode strap. After a fixed initialization delay, and once the external program request is released, it accepts the bitstream. When the loader reports that all data has arrived, it runs an ordered wake-up and releases DONE.

A restart can come from three sources in any phase after initialization: a program request held low long enough, a one-cycle refresh command, or loss of any supply flag. Each sends the controller back through the reset phase. If the init line is seen low while data is loading, the controller parks in an error phase and stays there until a restart arrives. The program request and the init line are both passed through two-flop synchronizers before use. The rail flags, the refresh command and the load-complete flag are assumed to be synchronous to `clk`.

Top module: `boot_sequencer`

## Requirements
- R1: While any of `core_ok`, `aux_ok`, `cfgio_ok` is low, the controller stays in the reset phase, and `gsr_release`, `gwe_en` and `goe_en` stay low so that user I/O is high impedance.
- R2: During reset and in the cycle after any restart, `init_drive_low` and `done_drive_low` are both 1.
- R3: On the clock edge that leaves the reset phase with all rails good, `init_drive_low` drops to 0 and `mode_latched` takes the value of `mode_strap`. The latched mode holds until the next such edge.
- R4: The initialization phase ends only after `INIT_WAIT` cycles have passed and the synchronized program request is high. `load_done` has no effect in this phase. With the request high and `load_done` high, `gsr_release` rises `INIT_WAIT + 2 + WAKE_GAP` edges after the edge that entered initialization.
- R5: `prog_req_n` triggers a restart only if its synchronized copy is low for at least `PROG_MIN` consecutive cycles. A shorter low pulse leaves every output unchanged.
- R6: A low program request during initialization, of any length, does not restart the sequence.
- R7: In the loading, wake-up, user and error phases, three events each force the reset phase on the next edge: a qualified program request, `refresh_cmd` high for one cycle, or any rail flag low.
- R8: Counting from the edge that enters wake-up, `gsr_release` rises `WAKE_GAP` edges later, `gwe_en` rises `2*WAKE_GAP` edges later and `goe_en` rises `3*WAKE_GAP` edges later. `done_drive_low` falls `4*WAKE_GAP` edges later, which is user mode. Each signal stays high until a restart.
- R9: If the synchronized `init_line_n` is low while loading, the controller enters the error phase, with `init_drive_low` = 1 and `done_drive_low` = 1.
- R10: The error phase ignores `load_done` and stays put. Only a restart event from R7 leaves it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_ok | input | 1 | Core supply good |
| aux_ok | input | 1 | Auxiliary supply good |
| cfgio_ok | input | 1 | Configuration I/O supply good |
| prog_req_n | input | 1 | Asynchronous active-low program request |
| init_line_n | input | 1 | Readback of the open-drain init line, asynchronous |
| mode_strap | input | 3 | Boot-mode strap pins |
| refresh_cmd | input | 1 | One-cycle restart command |
| load_done | input | 1 | Bitstream loader finished |
| init_drive_low | output | 1 | Enable for the pull-down on the init line |
| done_drive_low | output | 1 | Enable for the pull-down on DONE |
| mode_latched | output | 3 | Strap value captured when initialization starts |
| gsr_release | output | 1 | Global set/reset released |
| gwe_en | output | 1 | Global write enable |
| goe_en | output | 1 | Global output enable |

## Verification
The bench builds the block with `INIT_WAIT` = 20, `PROG_MIN` = 4 and `WAKE_GAP` = 3. At these values one boot to user mode takes about 35 cycles, so every scenario can afford its own reset and full boot. This lets the bench check the exact edge of each wake-up step, and of the delayed exit from initialization, against the formulas in R4 and R8. A `PROG_MIN` of 4 makes the one-cycle gap between a pulse that is ignored (3 cycles) and one that is accepted (4 cycles) cheap to test.

// File: rtl/boot_seq_pkg.sv
// Package: shared phase encoding for the configuration sequencer.
// Assumes nothing beyond a 3-bit state register.
package boot_seq_pkg;

    typedef enum logic [2:0] {
        PH_RESET  = 3'd0,
        PH_INIT   = 3'd1,
        PH_LOAD   = 3'd2,
        PH_WAKE   = 3'd3,
        PH_USER   = 3'd4,
        PH_FAULT  = 3'd5
    } phase_t;

    // Number of wake-up steps before DONE is released.
    localparam int unsigned WAKE_STEPS = 3;

endpackage

// File: rtl/bs_sync.sv
// Module: multi-bit two-flop synchronizer.
// Each bit is independent. Reset loads RST_VAL so that idle-high lines start
// high. Assumes the bits need no mutual coherence.
module bs_sync #(
    parameter int unsigned         W       = 1,
    parameter logic [W-1:0]        RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] stage1;

    // Two-stage capture of the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end

endmodule

// File: rtl/bs_low_qual.sv
// Module: minimum low-width qualifier.
// Emits a one-cycle pulse on the MIN_LOW-th consecutive low cycle of a
// synchronized active-low input, and at most one pulse per low period.
// Assumes MIN_LOW >= 1 and a synchronous input.
module bs_low_qual #(
    parameter int unsigned MIN_LOW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_n,
    output logic hit
);

    localparam int unsigned CW = $clog2(MIN_LOW + 1);

    logic [CW-1:0] low_cnt;

    // Count consecutive low cycles, saturating at MIN_LOW.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (sig_n) begin
            low_cnt <= '0;
        end else if (low_cnt != CW'(MIN_LOW)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // Fire once, when the count is about to reach the minimum width.
    always_comb hit = !sig_n && (low_cnt == CW'(MIN_LOW - 1));

endmodule

// File: rtl/bs_phase_fsm.sv
// Module: phase controller with a shared delay timer and a wake-up step count.
// Takes already-synchronized program and init levels plus a qualified
// program pulse, and drives every sequencer output. Assumes INIT_WAIT >= 1,
// WAKE_GAP >= 1, and rail, refresh and load flags synchronous to clk.
module bs_phase_fsm
    import boot_seq_pkg::*;
#(
    parameter int unsigned INIT_WAIT = 1024,
    parameter int unsigned WAKE_GAP  = 4,
    parameter int unsigned MODE_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rails_ok,
    input  logic              prog_level_n,
    input  logic              prog_hit,
    input  logic              init_level_n,
    input  logic [MODE_W-1:0] mode_strap,
    input  logic              refresh_cmd,
    input  logic              load_done,
    output logic              init_drive_low,
    output logic              done_drive_low,
    output logic [MODE_W-1:0] mode_latched,
    output logic              gsr_release,
    output logic              gwe_en,
    output logic              goe_en
);

    localparam int unsigned TMAX = (INIT_WAIT > WAKE_GAP) ? INIT_WAIT : WAKE_GAP;
    localparam int unsigned TW   = $clog2(TMAX + 1);
    localparam int unsigned SW   = $clog2(WAKE_STEPS + 1);

    phase_t        phase, phase_nxt;
    logic [TW-1:0] tmr;
    logic [SW-1:0] wstep;
    logic          init_expired, wake_tick, restart;

    // Timer and restart conditions used by the transition logic.
    always_comb begin
        init_expired = (tmr == TW'(INIT_WAIT));
        wake_tick    = (tmr == TW'(WAKE_GAP - 1));
        restart      = !rails_ok || prog_hit || refresh_cmd;
    end

    // Next-phase decode.
    always_comb begin
        phase_nxt = phase;
        case (phase)
            PH_RESET: if (rails_ok) phase_nxt = PH_INIT;
            PH_INIT: begin
                if (!rails_ok)                         phase_nxt = PH_RESET;
                else if (init_expired && prog_level_n) phase_nxt = PH_LOAD;
            end
            PH_LOAD: begin
                if (restart)            phase_nxt = PH_RESET;
                else if (!init_level_n) phase_nxt = PH_FAULT;
                else if (load_done)     phase_nxt = PH_WAKE;
            end
            PH_WAKE: begin
                if (restart) phase_nxt = PH_RESET;
                else if (wake_tick && wstep == SW'(WAKE_STEPS)) phase_nxt = PH_USER;
            end
            PH_USER:  if (restart) phase_nxt = PH_RESET;
            PH_FAULT: if (restart) phase_nxt = PH_RESET;
            default:  phase_nxt = PH_RESET;
        endcase
    end

    // Phase register, shared timer, wake step counter and mode capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase        <= PH_RESET;
            tmr          <= '0;
            wstep        <= '0;
            mode_latched <= '0;
        end else begin
            phase <= phase_nxt;
            if (phase_nxt != phase) begin
                tmr   <= '0;
                wstep <= '0;
            end else if (phase == PH_INIT) begin
                if (!init_expired) tmr <= tmr + 1'b1;
            end else if (phase == PH_WAKE) begin
                if (wake_tick) begin
                    tmr   <= '0;
                    wstep <= wstep + 1'b1;
                end else begin
                    tmr <= tmr + 1'b1;
                end
            end
            if (phase == PH_RESET && phase_nxt == PH_INIT) mode_latched <= mode_strap;
        end
    end

    // Output decode from phase and wake step.
    always_comb begin
        init_drive_low = (phase == PH_RESET) || (phase == PH_FAULT);
        done_drive_low = (phase != PH_USER);
        gsr_release    = (phase == PH_USER) || (phase == PH_WAKE && wstep >= SW'(1));
        gwe_en         = (phase == PH_USER) || (phase == PH_WAKE && wstep >= SW'(2));
        goe_en         = (phase == PH_USER) || (phase == PH_WAKE && wstep >= SW'(3));
    end

endmodule

// File: rtl/boot_sequencer.sv
// Module: top of the power-on configuration sequencer.
// Synchronizes the program request and the init readback, qualifies the
// program request by width, and hands both to the phase controller.
// Assumes the rail, refresh and load flags are synchronous to clk.
module boot_sequencer #(
    parameter int unsigned INIT_WAIT = 1024,
    parameter int unsigned PROG_MIN  = 8,
    parameter int unsigned WAKE_GAP  = 4,
    parameter int unsigned MODE_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_ok,
    input  logic              aux_ok,
    input  logic              cfgio_ok,
    input  logic              prog_req_n,
    input  logic              init_line_n,
    input  logic [MODE_W-1:0] mode_strap,
    input  logic              refresh_cmd,
    input  logic              load_done,
    output logic              init_drive_low,
    output logic              done_drive_low,
    output logic [MODE_W-1:0] mode_latched,
    output logic              gsr_release,
    output logic              gwe_en,
    output logic              goe_en
);

    logic [1:0] lines_sync;
    logic       prog_hit;
    logic       rails_ok;

    // All three supplies must report good.
    always_comb rails_ok = core_ok && aux_ok && cfgio_ok;

    bs_sync #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({init_line_n, prog_req_n}),
        .q_sync  (lines_sync)
    );

    bs_low_qual #(.MIN_LOW(PROG_MIN)) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_n (lines_sync[0]),
        .hit   (prog_hit)
    );

    bs_phase_fsm #(
        .INIT_WAIT (INIT_WAIT),
        .WAKE_GAP  (WAKE_GAP),
        .MODE_W    (MODE_W)
    ) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .rails_ok       (rails_ok),
        .prog_level_n   (lines_sync[0]),
        .prog_hit       (prog_hit),
        .init_level_n   (lines_sync[1]),
        .mode_strap     (mode_strap),
        .refresh_cmd    (refresh_cmd),
        .load_done      (load_done),
        .init_drive_low (init_drive_low),
        .done_drive_low (done_drive_low),
        .mode_latched   (mode_latched),
        .gsr_release    (gsr_release),
        .gwe_en         (gwe_en),
        .goe_en         (goe_en)
    );

endmodule

// File: rtl/boot_sequencer_chk.sv
// Module: property checker for boot_sequencer, attached with bind.
// Observes top-level ports only.
module boot_sequencer_chk #(
    parameter int unsigned MODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              core_ok,
    input logic              aux_ok,
    input logic              cfgio_ok,
    input logic              init_drive_low,
    input logic              done_drive_low,
    input logic [MODE_W-1:0] mode_latched,
    input logic              gsr_release,
    input logic              gwe_en,
    input logic              goe_en
);

    AST_RAIL_LOSS_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_ok && aux_ok && cfgio_ok) |=> (init_drive_low && done_drive_low && !goe_en)); // R7

    AST_RESET_IO_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        init_drive_low |-> (!goe_en && !gwe_en && !gsr_release)); // R1

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_drive_low && $past(!init_drive_low)) |-> $stable(mode_latched)); // R3

    AST_WAKE_OE_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        goe_en |-> gwe_en); // R8

    AST_WAKE_WE_AFTER_GSR: assert property (@(posedge clk) disable iff (!rst_n)
        gwe_en |-> gsr_release); // R8

    AST_DONE_AFTER_OE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_drive_low) |-> $past(goe_en)); // R8

    AST_USER_FULLY_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        !done_drive_low |-> (goe_en && !init_drive_low)); // R2

endmodule

bind boot_sequencer boot_sequencer_chk #(.MODE_W(MODE_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .core_ok        (core_ok),
    .aux_ok         (aux_ok),
    .cfgio_ok       (cfgio_ok),
    .init_drive_low (init_drive_low),
    .done_drive_low (done_drive_low),
    .mode_latched   (mode_latched),
    .gsr_release    (gsr_release),
    .gwe_en         (gwe_en),
    .goe_en         (goe_en)
);

// File: tb/sim_boot_sequencer.sv
// Bench: directed scenarios for boot_sequencer, one task each.
module sim_boot_sequencer;

    localparam int unsigned NW = 20;   // INIT_WAIT
    localparam int unsigned NP = 4;    // PROG_MIN
    localparam int unsigned NG = 3;    // WAKE_GAP

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       core_ok = 1'b1, aux_ok = 1'b1, cfgio_ok = 1'b1;
    logic       prog_req_n = 1'b1, init_line_n = 1'b1;
    logic [2:0] mode_strap = 3'd0;
    logic       refresh_cmd = 1'b0, load_done = 1'b0;
    logic       init_drive_low, done_drive_low, gsr_release, gwe_en, goe_en;
    logic [2:0] mode_latched;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int t0     = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    boot_sequencer #(.INIT_WAIT(NW), .PROG_MIN(NP), .WAKE_GAP(NG), .MODE_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .core_ok(core_ok), .aux_ok(aux_ok),
        .cfgio_ok(cfgio_ok), .prog_req_n(prog_req_n), .init_line_n(init_line_n),
        .mode_strap(mode_strap), .refresh_cmd(refresh_cmd), .load_done(load_done),
        .init_drive_low(init_drive_low), .done_drive_low(done_drive_low),
        .mode_latched(mode_latched), .gsr_release(gsr_release),
        .gwe_en(gwe_en), .goe_en(goe_en)
    );

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic sig(input int which);
        case (which)
            0: sig = gsr_release;
            1: sig = gwe_en;
            2: sig = goe_en;
            default: sig = !done_drive_low;
        endcase
    endfunction

    task automatic wait_sig(input int which, output int at);
        for (int i = 0; i < 200 && !sig(which); i++) tick();
        at = cyc;
    endtask

    task automatic do_reset(input logic ld);
        rst_n = 1'b0;
        core_ok = 1'b1; aux_ok = 1'b1; cfgio_ok = 1'b1;
        prog_req_n = 1'b1; init_line_n = 1'b1; refresh_cmd = 1'b0;
        load_done = ld;
        repeat (3) tick();
        rst_n = 1'b1;
        t0 = cyc;
    endtask

    // Reset outputs, holding in the reset phase while a rail is low, and mode capture.
    task automatic t_power_up();
        int at;
        rst_n = 1'b0; mode_strap = 3'd5; cfgio_ok = 1'b0; load_done = 1'b1;
        repeat (3) tick();
        chk("R2", init_drive_low, 1, "init drive during reset");
        chk("R2", done_drive_low, 1, "done drive during reset");
        rst_n = 1'b1;
        repeat (10) tick();
        chk("R1", init_drive_low, 1, "still in reset with cfgio rail low");
        chk("R1", goe_en, 0, "outputs high-Z with rail low");
        chk("R1", gsr_release, 0, "gsr held with rail low");
        cfgio_ok = 1'b1;
        tick();
        chk("R3", init_drive_low, 0, "init released on rails good");
        chk("R3", mode_latched, 5, "strap latched");
        mode_strap = 3'd2;
        wait_sig(3, at);
        chk("R3", mode_latched, 5, "latched mode unaffected by strap change");
        chk("R2", init_drive_low, 0, "init released in user mode");
    endtask

    // Exact timing of the initialization exit and of each wake-up step.
    task automatic t_boot_timing();
        int at;
        do_reset(1'b1);
        wait_sig(0, at);
        chk("R4", at - t0, 1 + NW + 2 + NG, "gsr release edge");
        wait_sig(1, at);
        chk("R8", at - t0, 1 + NW + 2 + 2 * NG, "write enable edge");
        wait_sig(2, at);
        chk("R8", at - t0, 1 + NW + 2 + 3 * NG, "output enable edge");
        wait_sig(3, at);
        chk("R8", at - t0, 1 + NW + 2 + 4 * NG, "done release edge");
        repeat (5) tick();
        chk("R8", {gsr_release, gwe_en, goe_en, done_drive_low}, 4'b1110, "user outputs stay");
    endtask

    // Program requests during initialization: ignored; a held request delays the exit.
    task automatic t_init_prog();
        int at, r, bad;
        do_reset(1'b1);
        bad = 0;
        prog_req_n = 1'b0;
        for (int i = 0; i < NP + 2; i++) begin
            tick();
            if (init_drive_low) bad++;
        end
        prog_req_n = 1'b1;
        chk("R6", bad, 0, "no restart from qualified request in init");
        wait_sig(0, at);
        chk("R6", at - t0, 1 + NW + 2 + NG, "gsr timing unchanged after request in init");
        do_reset(1'b1);
        prog_req_n = 1'b0;
        repeat (NW + 10) tick();
        chk("R4", gsr_release, 0, "no wake while request held");
        chk("R6", init_drive_low, 0, "held request does not restart");
        r = cyc;
        prog_req_n = 1'b1;
        wait_sig(0, at);
        chk("R4", at - r, 4 + NG, "exit after request release");
    endtask

    // Width qualification of the program request in user mode.
    task automatic t_prog_qual();
        int at;
        do_reset(1'b1);
        wait_sig(3, at);
        prog_req_n = 1'b0;
        repeat (NP - 1) tick();
        prog_req_n = 1'b1;
        repeat (8) tick();
        chk("R5", done_drive_low, 0, "short pulse ignored, done");
        chk("R5", goe_en, 1, "short pulse ignored, oe");
        prog_req_n = 1'b0;
        repeat (NP) tick();
        prog_req_n = 1'b1;
        repeat (4) tick();
        chk("R5", done_drive_low, 1, "full-width pulse restarts");
        chk("R7", gsr_release, 0, "restart clears wake outputs");
        wait_sig(3, at);
        chk("R7", done_drive_low, 0, "returns to user after restart");
    endtask

    // Refresh command, rail loss and mode recapture.
    task automatic t_refresh_rails();
        int at;
        do_reset(1'b1);
        mode_strap = 3'd1;
        wait_sig(3, at);
        refresh_cmd = 1'b1;
        tick();
        refresh_cmd = 1'b0;
        chk("R2", {init_drive_low, done_drive_low}, 2'b11, "both driven after refresh command");
        chk("R7", goe_en, 0, "refresh command drops oe");
        wait_sig(3, at);
        aux_ok = 1'b0;
        tick();
        chk("R7", {init_drive_low, done_drive_low}, 2'b11, "rail loss restarts");
        chk("R1", goe_en, 0, "rail loss gives high-Z");
        mode_strap = 3'd6;
        repeat (5) tick();
        chk("R1", init_drive_low, 1, "held in reset while aux low");
        aux_ok = 1'b1;
        tick();
        chk("R3", init_drive_low, 0, "init released on rail return");
        chk("R3", mode_latched, 6, "mode recaptured");
    endtask

    // Init line low during loading: fault phase, exit only by restart.
    task automatic t_fault();
        do_reset(1'b0);
        repeat (NW + 6) tick();
        chk("R9", init_drive_low, 0, "in loading phase");
        init_line_n = 1'b0;
        repeat (2) tick();
        init_line_n = 1'b1;
        repeat (3) tick();
        chk("R9", init_drive_low, 1, "fault drives init low");
        chk("R9", done_drive_low, 1, "fault holds done low");
        load_done = 1'b1;
        repeat (12) tick();
        chk("R10", init_drive_low, 1, "fault ignores load_done");
        chk("R10", gsr_release, 0, "no wake from fault");
        refresh_cmd = 1'b1;
        tick();
        refresh_cmd = 1'b0;
        tick();
        chk("R10", init_drive_low, 0, "refresh leaves fault");
    endtask

    task automatic run_all();
        @(negedge clk);
        t_power_up();
        t_boot_timing();
        t_init_prog();
        t_prog_qual();
        t_refresh_rails();
        t_fault();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL R0 watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule